// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides whether a memory access falls inside one of a small set of programmable windows that skip page-table translation. A hit means the logical address is used as the physical address unchanged. Each window has an enable bit, a base value and a don't-care mask, both applied to the upper byte of the address. It also has a privilege selector and a write-protect bit. Only the top eight address bits are compared, so every window spans at least 16 MB. Two windows may cover separate regions, or they may overlap.

A translation unit drives the access address, the privilege level and a flag for write or read-modify-write, together with the window settings. The block returns three things: a hit flag, the index of the window that won, and an abort request. The abort request is raised for a write into a protected window. A parameter selects one of two timings. In the combinational form the result is valid in the same cycle as the inputs. In the registered form the result appears one clock later.

Top module: `tt_window_matcher`

## Requirements
- R1: A window whose enable bit is 0 never matches, whatever its other fields and the access hold.
- R2: Only address bits [31:24] take part in the compare; bits [23:0] never change the result.
- R3: When bit k of a window's mask is 1, address bit 24+k is not compared against base bit k.
- R4: The 2-bit privilege selector is read as follows: 00 matches only user accesses (`acc_sup`=0), 01 matches only supervisor accesses (`acc_sup`=1), and 10 or 11 match both.
- R5: A window matches only if its privilege condition holds and every unmasked base bit equals the corresponding address bit.
- R6: `abort_req` is 1 exactly when a window is selected, that window's write-protect bit is 1, and `acc_wr`=1. A read into a protected window is not aborted.
- R7: When both windows match, window 0 wins. `hit_idx` is 0 and the write-protect bit of window 0 alone decides the abort.
- R8: When no window matches, `hit`, `hit_idx` and `abort_req` are all 0.
- R9: With `REG_OUT`=1, the outputs show the result for the inputs sampled at the previous rising clock edge. A clock edge with `rst_n`=0 forces all outputs to 0.
- R10: With `REG_OUT`=0, the outputs are a combinational function of the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when REG_OUT=1) |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W | Logical address of the access |
| acc_sup | input | 1 | 1 = supervisor access, 0 = user access |
| acc_wr | input | 1 | 1 = write or read-modify-write |
| win_en | input | N_WIN | Per-window enable |
| win_base | input | N_WIN*CMP_W | Per-window base for the upper address bits (window w at [w*CMP_W +: CMP_W]) |
| win_mask | input | N_WIN*CMP_W | Per-window don't-care mask |
| win_psel | input | 2*N_WIN | Per-window privilege selector |
| win_wp | input | N_WIN | Per-window write-protect |
| hit | output | 1 | Some window matched |
| hit_idx | output | IDX_W | Index of the selected window |
| abort_req | output | 1 | Write into a protected window |

## Verification
The bench builds two copies that differ only in timing. Both use the default two windows with 8 compare bits. One copy has `REG_OUT`=0 and is checked against the reference model in the same cycle. The other has `REG_OUT`=1 and is checked against the result the model produced one edge earlier. This covers the one-cycle latency and the clearing of outputs during reset, alongside the matching logic. The stimulus is directed first: disabled windows, masked bits, each privilege code, overlapping windows and protected reads versus writes. A long random run with narrow masks and variable low address bits follows.

// File: rtl/tt_pkg.sv
// Shared constants and types for the transparent translation window matcher.
// Assumes windows are compared on the most significant address byte.
package tt_pkg;
    localparam int TT_CMP_W  = 8;
    localparam int TT_PSEL_W = 2;

    // Privilege selector codes; bit 1 set means either level matches.
    typedef enum logic [TT_PSEL_W-1:0] {
        PSEL_USER = 2'b00,
        PSEL_SUPV = 2'b01,
        PSEL_ANY  = 2'b10,
        PSEL_ANY2 = 2'b11
    } psel_e;

    // Combined result of the window search.
    typedef struct packed {
        logic hit;
        logic abort;
    } tt_flags_t;
endpackage

// File: rtl/tt_window_cmp.sv
// Compares one access against one transparent translation window.
// Assumes addr_hi already holds only the compared upper address bits.
module tt_window_cmp
    import tt_pkg::*;
#(
    parameter int CMP_W = TT_CMP_W
) (
    input  logic [CMP_W-1:0]     addr_hi,
    input  logic                 acc_sup,
    input  logic                 en,
    input  logic [CMP_W-1:0]     base,
    input  logic [CMP_W-1:0]     mask,
    input  logic [TT_PSEL_W-1:0] psel,
    output logic                 match
);
    logic priv_ok;
    logic addr_ok;

    // Privilege condition from the selector code.
    always_comb begin
        unique case (psel_e'(psel))
            PSEL_USER: priv_ok = !acc_sup;
            PSEL_SUPV: priv_ok = acc_sup;
            default:   priv_ok = 1'b1;
        endcase
    end

    // Unmasked bits must agree; window must be enabled.
    always_comb begin
        addr_ok = ((addr_hi ^ base) & ~mask) == '0;
        match   = en && priv_ok && addr_ok;
    end
endmodule

// File: rtl/tt_prio_sel.sv
// Picks the lowest-numbered matching window and forms the abort request.
// Assumes the match and write-protect vectors are indexed by window number.
module tt_prio_sel
    import tt_pkg::*;
#(
    parameter int N_WIN = 2,
    parameter int IDX_W = 1
) (
    input  logic [N_WIN-1:0] match,
    input  logic [N_WIN-1:0] wp,
    input  logic             acc_wr,
    output tt_flags_t        flags,
    output logic [IDX_W-1:0] idx
);
    // Scan from the highest index down so the lowest match is kept last.
    always_comb begin
        flags.hit   = 1'b0;
        flags.abort = 1'b0;
        idx         = '0;
        for (int w = N_WIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                flags.hit   = 1'b1;
                flags.abort = wp[w] && acc_wr;
                idx         = IDX_W'(w);
            end
        end
    end
endmodule

// File: rtl/tt_window_matcher.sv
// Top of the transparent translation window matcher: one comparator per
// window, a priority select, and an optional output register stage.
// Assumes window fields are packed with window w in slice w of each bus.
module tt_window_matcher
    import tt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CMP_W   = TT_CMP_W,
    parameter int N_WIN   = 2,
    parameter bit REG_OUT = 1'b0,
    localparam int IDX_W  = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic                       acc_sup,
    input  logic                       acc_wr,
    input  logic [N_WIN-1:0]           win_en,
    input  logic [N_WIN*CMP_W-1:0]     win_base,
    input  logic [N_WIN*CMP_W-1:0]     win_mask,
    input  logic [N_WIN*TT_PSEL_W-1:0] win_psel,
    input  logic [N_WIN-1:0]           win_wp,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx,
    output logic                       abort_req
);
    logic [CMP_W-1:0] addr_hi;
    logic [N_WIN-1:0] match;
    tt_flags_t        flags_c;
    logic [IDX_W-1:0] idx_c;

    assign addr_hi = acc_addr[ADDR_W-1 -: CMP_W];

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        tt_window_cmp #(.CMP_W(CMP_W)) u_cmp (
            .addr_hi (addr_hi),
            .acc_sup (acc_sup),
            .en      (win_en[w]),
            .base    (win_base[w*CMP_W +: CMP_W]),
            .mask    (win_mask[w*CMP_W +: CMP_W]),
            .psel    (win_psel[w*TT_PSEL_W +: TT_PSEL_W]),
            .match   (match[w])
        );
    end

    tt_prio_sel #(.N_WIN(N_WIN), .IDX_W(IDX_W)) u_sel (
        .match  (match),
        .wp     (win_wp),
        .acc_wr (acc_wr),
        .flags  (flags_c),
        .idx    (idx_c)
    );

    if (REG_OUT) begin : g_reg
        tt_flags_t        flags_q;
        logic [IDX_W-1:0] idx_q;

        // Output stage: capture the search result, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q <= '0;
                idx_q   <= '0;
            end else begin
                flags_q <= flags_c;
                idx_q   <= idx_c;
            end
        end

        assign hit       = flags_q.hit;
        assign abort_req = flags_q.abort;
        assign hit_idx   = idx_q;
    end else begin : g_comb
        assign hit       = flags_c.hit;
        assign abort_req = flags_c.abort;
        assign hit_idx   = idx_c;
    end
endmodule

// File: rtl/tt_window_matcher_chk.sv
// Checker for tt_window_matcher. It keeps its own copy of the inputs, aligned
// with the output timing, and relates the outputs to those copies.
// Assumes the same parameters as the block it is bound to.
module tt_window_matcher_chk
    import tt_pkg::*;
#(
    parameter int N_WIN   = 2,
    parameter bit REG_OUT = 1'b0,
    parameter int IDX_W   = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       acc_sup,
    input logic                       acc_wr,
    input logic [N_WIN-1:0]           win_en,
    input logic [N_WIN*TT_PSEL_W-1:0] win_psel,
    input logic [N_WIN-1:0]           win_wp,
    input logic                       hit,
    input logic [IDX_W-1:0]           hit_idx,
    input logic                       abort_req
);
    logic                       sup_v, wr_v;
    logic [N_WIN-1:0]           en_v, wp_v;
    logic [N_WIN*TT_PSEL_W-1:0] psel_v;

    if (REG_OUT) begin : g_dly
        logic                       sup_q, wr_q;
        logic [N_WIN-1:0]           en_q, wp_q;
        logic [N_WIN*TT_PSEL_W-1:0] psel_q;

        // Delay the inputs to line up with the registered outputs.
        always_ff @(posedge clk) begin
            sup_q  <= acc_sup;
            wr_q   <= acc_wr;
            en_q   <= win_en;
            wp_q   <= win_wp;
            psel_q <= win_psel;
        end
        assign sup_v = sup_q;
        assign wr_v = wr_q;
        assign en_v = en_q;
        assign wp_v = wp_q;
        assign psel_v = psel_q;

        p_reset_clear_r9: assert property (@(posedge clk)
            !rst_n |=> (!hit && !abort_req && hit_idx == '0));
    end else begin : g_now
        assign sup_v = acc_sup;
        assign wr_v = acc_wr;
        assign en_v = win_en;
        assign wp_v = win_wp;
        assign psel_v = win_psel;
    end

    logic [TT_PSEL_W-1:0] sel_psel;
    assign sel_psel = psel_v[hit_idx*TT_PSEL_W +: TT_PSEL_W];

    p_hit_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> en_v[hit_idx]);
    p_user_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel_psel == PSEL_USER) |-> !sup_v);
    p_supv_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel_psel == PSEL_SUPV) |-> sup_v);
    p_abort_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (hit && wr_v && wp_v[hit_idx]));
    p_abort_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_v && wp_v[hit_idx]) |-> abort_req);
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!abort_req && hit_idx == '0));
endmodule

bind tt_window_matcher tt_window_matcher_chk #(
    .N_WIN(N_WIN), .REG_OUT(REG_OUT), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_sup(acc_sup), .acc_wr(acc_wr),
    .win_en(win_en), .win_psel(win_psel), .win_wp(win_wp),
    .hit(hit), .hit_idx(hit_idx), .abort_req(abort_req)
);

// File: tb/sim_tt_window_matcher.sv
// Bench: a behavioural model is compared every cycle against a combinational
// instance (u1) and, one edge later, against a registered instance (u0).
module sim_tt_window_matcher;
    localparam int NW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        sup = 1'b0, wr = 1'b0;
    logic        en [NW];
    logic [7:0]  base [NW];
    logic [7:0]  mask [NW];
    logic [1:0]  psel [NW];
    logic        wp [NW];

    logic [NW-1:0]   en_f, wp_f;
    logic [NW*8-1:0] base_f, mask_f;
    logic [NW*2-1:0] psel_f;
    for (genvar w = 0; w < NW; w++) begin : g_pack
        assign en_f[w] = en[w];
        assign wp_f[w] = wp[w];
        assign base_f[w*8 +: 8] = base[w];
        assign mask_f[w*8 +: 8] = mask[w];
        assign psel_f[w*2 +: 2] = psel[w];
    end

    logic hit0, idx0, ab0, hit1, idx1, ab1;

    tt_window_matcher #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(addr), .acc_sup(sup), .acc_wr(wr),
        .win_en(en_f), .win_base(base_f), .win_mask(mask_f), .win_psel(psel_f),
        .win_wp(wp_f), .hit(hit0), .hit_idx(idx0), .abort_req(ab0));

    tt_window_matcher #(.REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_addr(addr), .acc_sup(sup), .acc_wr(wr),
        .win_en(en_f), .win_base(base_f), .win_mask(mask_f), .win_psel(psel_f),
        .win_wp(wp_f), .hit(hit1), .hit_idx(idx1), .abort_req(ab1));

    always #2 clk = ~clk;

    int    checks = 0, errors = 0;
    string tag = "R8";

    // Reference: returns {hit, idx, abort}
    function automatic logic [2:0] model();
        for (int w = 0; w < NW; w++) begin
            bit priv_ok, addr_ok;
            priv_ok = psel[w][1] ? 1'b1 : (psel[w][0] ? sup : !sup);
            addr_ok = 1'b1;
            for (int b = 0; b < 8; b++)
                if (!mask[w][b] && addr[24+b] != base[w][b]) addr_ok = 1'b0;
            if (en[w] && priv_ok && addr_ok)
                return {1'b1, w[0], wp[w] & wr};
        end
        return 3'b000;
    endfunction

    logic [2:0] exp_q = 3'b000;
    always @(posedge clk) exp_q <= rst_n ? model() : 3'b000;

    task automatic cmp(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (hit,idx,abort)", req, act, exp);
        end
    endtask

    // One cycle: let an edge pass, then check both instances away from it.
    task automatic tick();
        @(posedge clk);
        #1;
        cmp({tag, "/R10"}, {hit1, idx1, ab1}, model());
        cmp({tag, "/R9"},  {hit0, idx0, ab0}, exp_q);
    endtask

    task automatic setw(int w, logic e, logic [7:0] b, logic [7:0] m,
                        logic [1:0] p, logic pr);
        en[w] = e; base[w] = b; mask[w] = m; psel[w] = p; wp[w] = pr;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        setw(0, 1, 8'h40, 8'h00, 2'b10, 1);
        setw(1, 0, 8'h00, 8'h00, 2'b10, 0);
        addr = 32'h4000_0000; wr = 1;
        // R9: reset clears registered outputs even while a hit is present.
        tag = "R9";
        @(posedge clk); #1;
        cmp("R9 reset", {hit0, idx0, ab0}, 3'b000);
        rst_n = 1'b1;
        tick();
        cmp("R9 latency", {hit0, idx0, ab0}, 3'b101);

        // R1: window 0 disabled, window 1 enabled at same base
        tag = "R1";
        setw(0, 0, 8'h40, 8'h00, 2'b10, 1);
        setw(1, 1, 8'h40, 8'h00, 2'b10, 0);
        tick(); tick();
        cmp("R1 idx1", {hit1, idx1, ab1}, 3'b110);
        setw(1, 0, 8'h40, 8'h00, 2'b10, 0);
        tick();
        cmp("R1 none", {hit1, idx1, ab1}, 3'b000);

        // R2: low 24 bits ignored
        tag = "R2";
        setw(0, 1, 8'hA5, 8'h00, 2'b10, 0);
        wr = 0;
        addr = 32'hA5FF_FFFF; tick();
        cmp("R2 ones", {hit1, idx1, ab1}, 3'b100);
        addr = 32'hA512_3456; tick();
        addr = 32'hA4FF_FFFF; tick();
        cmp("R2 top", {hit1, idx1, ab1}, 3'b000);

        // R3: masked bits are don't-care
        tag = "R3";
        setw(0, 1, 8'hA0, 8'h0F, 2'b10, 0);
        addr = 32'hAF00_0000; tick();
        cmp("R3 masked", {hit1, idx1, ab1}, 3'b100);
        addr = 32'hB000_0000; tick();
        cmp("R3 unmasked", {hit1, idx1, ab1}, 3'b000);

        // R4/R5: privilege codes
        tag = "R4";
        addr = 32'hA000_0000;
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                setw(0, 1, 8'hA0, 8'h00, 2'(p), 0);
                sup = s[0];
                tick();
                cmp("R4 psel", {hit1, idx1, ab1},
                    {(p >= 2) || (p == 1 && s == 1) || (p == 0 && s == 0), 2'b00});
            end
        end
        tag = "R5";
        setw(0, 1, 8'hA0, 8'h00, 2'b01, 0); sup = 0; tick();
        cmp("R5 priv fails", {hit1, idx1, ab1}, 3'b000);
        sup = 1; addr = 32'hA100_0000; tick();
        cmp("R5 base fails", {hit1, idx1, ab1}, 3'b000);

        // R6: protected read vs write
        tag = "R6";
        setw(0, 1, 8'hA0, 8'h00, 2'b10, 1);
        addr = 32'hA000_0000; wr = 0; tick();
        cmp("R6 read", {hit1, idx1, ab1}, 3'b100);
        wr = 1; tick();
        cmp("R6 write", {hit1, idx1, ab1}, 3'b101);

        // R7: overlap, window 0 wins including its write-protect
        tag = "R7";
        setw(0, 1, 8'hA0, 8'h0F, 2'b10, 0);
        setw(1, 1, 8'hA3, 8'h00, 2'b10, 1);
        addr = 32'hA300_0000; tick();
        cmp("R7 prio", {hit1, idx1, ab1}, 3'b100);
        addr = 32'hA000_0000; tick();

        // R8: no match even with protection and write
        tag = "R8";
        addr = 32'h1200_0000; tick();
        cmp("R8 idle", {hit1, idx1, ab1}, 3'b000);

        // Random run
        tag = "R5";
        for (int i = 0; i < 2000; i++) begin
            for (int w = 0; w < NW; w++)
                setw(w, $urandom_range(0, 3) != 0, 8'($urandom_range(0, 255)) & 8'hF3,
                     8'($urandom_range(0, 255)) & 8'h0C, 2'($urandom_range(0, 3)),
                     1'($urandom_range(0, 1)));
            addr = {8'($urandom_range(0, 255)) & 8'hF3, 24'($urandom)};
            sup = 1'($urandom_range(0, 1));
            wr = 1'($urandom_range(0, 1));
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule